// File: doc/BRIEF.md
# Per-Line VBI Mode Resolver

This block keeps the slicing configuration for every line of the vertical blanking interval. There is one mode byte for each of lines 6 to 27 in each field, which makes 44 bytes. There is also a global full-field mode byte, a full-field enable, and a line-interrupt setting. Software loads all of these through a plain address/data port and can read them back. The read path is combinational.

When the video timing pulses `line_start`, the block takes the presented line number and field and resolves the effective configuration. A per-line byte other than FFh wins. A per-line byte of FFh, or a line outside the table, falls back to the full-field byte when full-field mode is on. With full-field mode off, such a line resolves to slicer-off. In PAL mode the table is indexed three lines further on. The resolved fields are registered at that edge and held until the next strobe. The slicer reads them for the whole line.

A separate comparator raises a one-cycle interrupt when the source line matches a programmed line number in an enabled field.

Top module: `vbi_line_mode_resolver`

## Requirements
- R1: After reset, every per-line byte reads FFh, the full-field byte reads 7Fh, and the enable and interrupt bytes read 00h. The resolved outputs show slicer-off (filter, route and reject at 1, correction at 0, service Fh), and `line_irq` is 0.
- R2: The per-line byte for line L (6..27) and field F is at address 2*(L-6)+F, where `field_id` is 0 for field 1 and 1 for field 2. The full-field byte is at 44, and the full-field enable is bit 0 of address 45. The interrupt byte is at 46. Any other address reads 00h, and writes to it are ignored.
- R3: A per-line byte other than FFh sets the resolved configuration for its line and field, whether full-field mode is on or off.
- R4: With full-field mode on, a line whose byte is FFh resolves from the full-field byte.
- R5: With full-field mode on, a line outside the table range resolves from the full-field byte.
- R6: With full-field mode off, a line with byte FFh or outside the table resolves to slicer-off (filter 1, route 1, reject 1, correction 0, service Fh).
- R7: The mode byte is decoded as follows: bit 7 filter, bit 6 FIFO route, bit 5 error reject, bit 3:0 service. Correction is output only when bit 4 is set and the service is 1, 2, 3 or 4.
- R8: With `pal_mode` high, source line N is resolved from the table entry for line N+3.
- R9: The resolved outputs change only on the clock edge at which `line_start` is high and appear in the following cycle. Register writes between strobes do not disturb them.
- R10: The interrupt byte holds a field-1 enable (bit 7), a field-2 enable (bit 6) and a line number (bits 5:0). `line_irq` pulses for one cycle, in the cycle after a strobe, when the source line equals that number and the current field is enabled. A programmed line of 0 or 1 never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| pal_mode | input | 1 | Apply the +3 line lookup offset |
| line_start | input | 1 | Start-of-line strobe |
| line_num | input | 10 | Source line number |
| field_id | input | 1 | 0 = field 1, 1 = field 2 |
| eff_filter | output | 1 | Resolved filter enable |
| eff_fifo_route | output | 1 | Resolved FIFO routing |
| eff_err_reject | output | 1 | Resolved error rejection |
| eff_edc | output | 1 | Resolved error-correction enable |
| eff_service | output | 4 | Resolved service code |
| line_irq | output | 1 | Line-match interrupt pulse |

## Verification
The assertions watch, on every cycle, that the outputs hold between strobes and that correction never appears with a service code outside 1..4. They also check that unmatched lines fall back to the full-field byte or to slicer-off as the enable dictates, and that the interrupt only follows a strobe and stays quiet for line settings 0 and 1. Only the directed scenarios can show that the address map places each line and field where R2 says, that the PAL offset picks the right entry, and that per-line bytes win over the full-field setting. They also show that writes to unmapped addresses leave no trace.

// File: rtl/vlm_pkg.sv
package vlm_pkg;

  typedef struct packed {
    logic       filter_en;
    logic       fifo_route;
    logic       err_reject;
    logic       edc_en;
    logic [3:0] service;
  } line_cfg_t;

  localparam logic [7:0] SLICER_OFF_BYTE = 8'hFF;
  localparam logic [7:0] FF_MODE_RESET   = 8'h7F;

  // services that carry a correctable code
  function automatic logic edc_capable(input logic [3:0] code);
    return (code >= 4'd1) && (code <= 4'd4);
  endfunction

  function automatic line_cfg_t decode_mode(input logic [7:0] m);
    line_cfg_t d;
    d.filter_en  = m[7];
    d.fifo_route = m[6];
    d.err_reject = m[5];
    d.edc_en     = m[4] && edc_capable(m[3:0]);
    d.service    = m[3:0];
    return d;
  endfunction

endpackage

// File: rtl/vlm_regbank.sv
module vlm_regbank #(
  parameter int NUM_REGS = 44,
  parameter int ADDR_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata,
  output logic [NUM_REGS-1:0][7:0] line_regs,
  output logic [7:0]               ff_mode,
  output logic                     ff_en,
  output logic [7:0]               irq_cfg
);
  import vlm_pkg::*;

  localparam logic [ADDR_W-1:0] A_FFMODE = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] A_FFEN   = ADDR_W'(NUM_REGS + 1);
  localparam logic [ADDR_W-1:0] A_IRQ    = ADDR_W'(NUM_REGS + 2);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)
        line_regs[g] <= SLICER_OFF_BYTE;
      else if (wr_en && addr == ADDR_W'(g))
        line_regs[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ff_mode <= FF_MODE_RESET;
      ff_en   <= 1'b0;
      irq_cfg <= 8'h00;
    end else if (wr_en) begin
      if (addr == A_FFMODE) ff_mode <= wdata;
      if (addr == A_FFEN)   ff_en   <= wdata[0];
      if (addr == A_IRQ)    irq_cfg <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) rdata = line_regs[i];
    if (addr == A_FFMODE) rdata = ff_mode;
    if (addr == A_FFEN)   rdata = {7'd0, ff_en};
    if (addr == A_IRQ)    rdata = irq_cfg;
  end

endmodule

// File: rtl/vlm_lookup.sv
module vlm_lookup #(
  parameter int FIRST_LINE = 6,
  parameter int NUM_LINES  = 22,
  parameter int LINE_W     = 10,
  parameter int PAL_SHIFT  = 3,
  localparam int NUM_REGS  = 2 * NUM_LINES,
  localparam int IDX_W     = LINE_W + 2
) (
  input  logic [LINE_W-1:0]        line_num,
  input  logic                     field_id,
  input  logic                     pal_mode,
  input  logic [NUM_REGS-1:0][7:0] line_regs,
  input  logic [7:0]               ff_mode,
  input  logic                     ff_en,
  output logic                     in_range,
  output logic                     per_is_ff,
  output logic [7:0]               sel_mode
);
  import vlm_pkg::*;

  localparam logic [LINE_W:0] LO = (LINE_W+1)'(FIRST_LINE);
  localparam logic [LINE_W:0] HI = (LINE_W+1)'(FIRST_LINE + NUM_LINES - 1);

  logic [LINE_W:0] table_line;
  logic [LINE_W:0] rel_line;
  logic [IDX_W-1:0] idx;
  logic [7:0]       per_val;

  always_comb begin
    table_line = {1'b0, line_num} + (pal_mode ? (LINE_W+1)'(PAL_SHIFT) : '0);
    in_range   = (table_line >= LO) && (table_line <= HI);
    rel_line   = table_line - LO;
    idx        = {rel_line, field_id};
    per_val    = SLICER_OFF_BYTE;
    if (in_range)
      for (int i = 0; i < NUM_REGS; i++)
        if (idx == IDX_W'(i)) per_val = line_regs[i];
    per_is_ff = (per_val == SLICER_OFF_BYTE);
    if (!per_is_ff)  sel_mode = per_val;
    else if (ff_en)  sel_mode = ff_mode;
    else             sel_mode = SLICER_OFF_BYTE;
  end

endmodule

// File: rtl/vlm_line_irq.sv
module vlm_line_irq #(
  parameter int LINE_W     = 10,
  parameter int IRQ_LINE_W = 6,
  parameter int MIN_LINE   = 2
) (
  input  logic [7:0]        irq_cfg,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_id,
  output logic              hit
);
  logic [IRQ_LINE_W-1:0] prog_line;
  logic                  fld_en;

  always_comb begin
    prog_line = irq_cfg[IRQ_LINE_W-1:0];
    fld_en    = field_id ? irq_cfg[6] : irq_cfg[7];
    hit       = fld_en && (prog_line >= IRQ_LINE_W'(MIN_LINE)) &&
                (line_num == LINE_W'(prog_line));
  end

endmodule

// File: rtl/vbi_line_mode_resolver.sv
module vbi_line_mode_resolver #(
  parameter int FIRST_LINE = 6,
  parameter int NUM_LINES  = 22,
  parameter int LINE_W     = 10,
  parameter int ADDR_W     = 8,
  parameter int PAL_SHIFT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              pal_mode,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_id,
  output logic              eff_filter,
  output logic              eff_fifo_route,
  output logic              eff_err_reject,
  output logic              eff_edc,
  output logic [3:0]        eff_service,
  output logic              line_irq
);
  import vlm_pkg::*;

  localparam int NUM_REGS = 2 * NUM_LINES;

  logic [NUM_REGS-1:0][7:0] line_regs;
  logic [7:0]  ff_mode_q;
  logic        ff_en_q;
  logic [7:0]  irq_cfg_q;
  logic        lk_in_range;
  logic        lk_per_is_ff;
  logic [7:0]  lk_sel_mode;
  logic        irq_hit;
  line_cfg_t   cfg_q;
  logic        irq_q;

  vlm_regbank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .line_regs(line_regs),
    .ff_mode(ff_mode_q), .ff_en(ff_en_q), .irq_cfg(irq_cfg_q)
  );

  vlm_lookup #(.FIRST_LINE(FIRST_LINE), .NUM_LINES(NUM_LINES),
               .LINE_W(LINE_W), .PAL_SHIFT(PAL_SHIFT)) u_lookup (
    .line_num(line_num), .field_id(field_id), .pal_mode(pal_mode),
    .line_regs(line_regs), .ff_mode(ff_mode_q), .ff_en(ff_en_q),
    .in_range(lk_in_range), .per_is_ff(lk_per_is_ff), .sel_mode(lk_sel_mode)
  );

  vlm_line_irq #(.LINE_W(LINE_W)) u_irq (
    .irq_cfg(irq_cfg_q), .line_num(line_num), .field_id(field_id), .hit(irq_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= decode_mode(SLICER_OFF_BYTE);
      irq_q <= 1'b0;
    end else begin
      if (line_start) cfg_q <= decode_mode(lk_sel_mode);
      irq_q <= line_start && irq_hit;
    end
  end

  assign eff_filter     = cfg_q.filter_en;
  assign eff_fifo_route = cfg_q.fifo_route;
  assign eff_err_reject = cfg_q.err_reject;
  assign eff_edc        = cfg_q.edc_en;
  assign eff_service    = cfg_q.service;
  assign line_irq       = irq_q;

endmodule

// File: rtl/vlm_checker.sv
module vlm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       line_start,
  input logic       eff_filter,
  input logic       eff_fifo_route,
  input logic       eff_err_reject,
  input logic       eff_edc,
  input logic [3:0] eff_service,
  input logic       line_irq,
  input logic       lk_in_range,
  input logic       lk_per_is_ff,
  input logic       ff_en_q,
  input logic [7:0] ff_mode_q,
  input logic [7:0] irq_cfg_q
);
  logic [7:0] eff_vec;
  assign eff_vec = {eff_filter, eff_fifo_route, eff_err_reject, eff_edc, eff_service};

  AST_HOLD_BETWEEN_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(eff_vec)); // R9

  AST_EDC_ONLY_CORRECTABLE: assert property (@(posedge clk) disable iff (!rst_n)
    eff_edc |-> (eff_service >= 4'd1 && eff_service <= 4'd4)); // R7

  AST_OFF_WHEN_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !ff_en_q && (!lk_in_range || lk_per_is_ff)) |=> (eff_vec == 8'hEF)); // R6

  AST_FULLFIELD_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && ff_en_q && lk_in_range && lk_per_is_ff) |=> (eff_service == $past(ff_mode_q[3:0]))); // R4

  AST_OUTSIDE_RANGE_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && ff_en_q && !lk_in_range) |=> (eff_service == $past(ff_mode_q[3:0]))); // R5

  AST_IRQ_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq |-> $past(line_start)); // R10

  AST_IRQ_LOW_LINE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cfg_q[5:0] < 6'd2) |=> !line_irq); // R10

endmodule

bind vbi_line_mode_resolver vlm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start),
  .eff_filter(eff_filter), .eff_fifo_route(eff_fifo_route),
  .eff_err_reject(eff_err_reject), .eff_edc(eff_edc),
  .eff_service(eff_service), .line_irq(line_irq),
  .lk_in_range(lk_in_range), .lk_per_is_ff(lk_per_is_ff),
  .ff_en_q(ff_en_q), .ff_mode_q(ff_mode_q), .irq_cfg_q(irq_cfg_q)
);

// File: tb/tb_vbi_line_mode_resolver.sv
module tb_vbi_line_mode_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_addr = 8'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [7:0] cfg_rdata;
  logic       pal_mode = 1'b0;
  logic       line_start = 1'b0;
  logic [9:0] line_num = 10'd0;
  logic       field_id = 1'b0;
  logic       eff_filter, eff_fifo_route, eff_err_reject, eff_edc, line_irq;
  logic [3:0] eff_service;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  vbi_line_mode_resolver dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pal_mode(pal_mode),
    .line_start(line_start), .line_num(line_num), .field_id(field_id),
    .eff_filter(eff_filter), .eff_fifo_route(eff_fifo_route),
    .eff_err_reject(eff_err_reject), .eff_edc(eff_edc),
    .eff_service(eff_service), .line_irq(line_irq)
  );

  wire [7:0] cfg_vec = {eff_filter, eff_fifo_route, eff_err_reject, eff_edc, eff_service};

  // slicer-off as seen on the outputs: 1,1,1,0,F
  localparam logic [7:0] OFF_VEC = 8'hEF;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic run_line(input int ln, input logic fld);
    @(negedge clk);
    line_num = 10'(ln); field_id = fld; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic t_reset;
    rd_check("R1 line reg 0", 8'd0, 8'hFF);
    rd_check("R1 line reg 43", 8'd43, 8'hFF);
    rd_check("R1 ff mode", 8'd44, 8'h7F);
    rd_check("R1 ff enable", 8'd45, 8'h00);
    rd_check("R1 irq byte", 8'd46, 8'h00);
    check("R1 outputs", cfg_vec, OFF_VEC);
    check("R1 irq low", {7'd0, line_irq}, 8'h00);
  endtask

  task automatic t_regmap;
    wr(8'd29, 8'h09);                       // line 20 field 2
    rd_check("R2 line20 f2", 8'd29, 8'h09);
    rd_check("R2 line20 f1 untouched", 8'd28, 8'hFF);
    wr(8'd47, 8'h55);
    rd_check("R2 unmapped 47", 8'd47, 8'h00);
    wr(8'd200, 8'h12);
    rd_check("R2 unmapped 200", 8'd200, 8'h00);
    rd_check("R2 ff mode after stray writes", 8'd44, 8'h7F);
    wr(8'd45, 8'h03);
    rd_check("R2 ff enable bit0 only", 8'd45, 8'h01);
    wr(8'd45, 8'h00);
  endtask

  task automatic t_offmode;
    run_line(20, 1'b0);
    check("R6 ff byte, ff off", cfg_vec, OFF_VEC);
    run_line(3, 1'b0);
    check("R6 out of range, ff off", cfg_vec, OFF_VEC);
  endtask

  task automatic t_perline;
    run_line(20, 1'b1);
    check("R3 per-line value", cfg_vec, 8'h09);
    wr(8'd44, 8'h47);
    wr(8'd45, 8'h01);
    run_line(20, 1'b1);
    check("R3 per-line beats full-field", cfg_vec, 8'h09);
  endtask

  task automatic t_fullfield;
    run_line(21, 1'b0);
    check("R4 ff fallback", cfg_vec, 8'h47);
    run_line(100, 1'b1);
    check("R5 above range", cfg_vec, 8'h47);
    run_line(2, 1'b0);
    check("R5 below range", cfg_vec, 8'h47);
    wr(8'd45, 8'h00);
  endtask

  task automatic t_edc;
    wr(8'd8, 8'h54);  run_line(10, 1'b0);
    check("R7 code4 bit4 -> edc", cfg_vec, 8'h54);
    wr(8'd8, 8'h15);  run_line(10, 1'b0);
    check("R7 code5 bit4 -> no edc", cfg_vec, 8'h05);
    wr(8'd8, 8'h11);  run_line(10, 1'b0);
    check("R7 code1 bit4 -> edc", cfg_vec, 8'h11);
    wr(8'd8, 8'h10);  run_line(10, 1'b0);
    check("R7 code0 bit4 -> no edc", cfg_vec, 8'h00);
    wr(8'd8, 8'hA3);  run_line(10, 1'b0);
    check("R7 flag bits", cfg_vec, 8'hA3);
  endtask

  task automatic t_pal;
    wr(8'd40, 8'h08);                       // line 26 field 1
    pal_mode = 1'b1;
    run_line(23, 1'b0);
    check("R8 pal line 23 uses 26", cfg_vec, 8'h08);
    wr(8'd0, 8'h0C);                        // line 6 field 1
    run_line(3, 1'b0);
    check("R8 pal line 3 uses 6", cfg_vec, 8'h0C);
    run_line(25, 1'b0);
    check("R8 pal line 25 past table", cfg_vec, OFF_VEC);
    pal_mode = 1'b0;
    run_line(23, 1'b0);
    check("R8 ntsc line 23 own entry", cfg_vec, OFF_VEC);
  endtask

  task automatic t_hold;
    pal_mode = 1'b1;
    run_line(23, 1'b0);
    check("R9 start value", cfg_vec, 8'h08);
    wr(8'd40, 8'h0B);
    wr(8'd45, 8'h01);
    repeat (3) @(negedge clk);
    check("R9 held mid-line", cfg_vec, 8'h08);
    run_line(23, 1'b0);
    check("R9 next strobe", cfg_vec, 8'h0B);
    pal_mode = 1'b0;
    wr(8'd45, 8'h00);
  endtask

  task automatic t_irq;
    wr(8'd46, 8'h94);                       // field 1 only, line 20
    run_line(20, 1'b0);
    check("R10 irq fires f1", {7'd0, line_irq}, 8'h01);
    @(negedge clk);
    check("R10 irq one cycle", {7'd0, line_irq}, 8'h00);
    run_line(20, 1'b1);
    check("R10 f2 disabled", {7'd0, line_irq}, 8'h00);
    run_line(21, 1'b0);
    check("R10 other line", {7'd0, line_irq}, 8'h00);
    wr(8'd46, 8'hC1);
    run_line(1, 1'b0);
    check("R10 line 1 silent", {7'd0, line_irq}, 8'h00);
    wr(8'd46, 8'hC0);
    run_line(0, 1'b1);
    check("R10 line 0 silent", {7'd0, line_irq}, 8'h00);
    wr(8'd46, 8'h55);                       // field 2 only, line 21
    run_line(21, 1'b1);
    check("R10 irq fires f2", {7'd0, line_irq}, 8'h01);
    run_line(85, 1'b1);
    check("R10 full line compare", {7'd0, line_irq}, 8'h00);
    pal_mode = 1'b1;
    run_line(21, 1'b1);
    check("R10 source line in pal", {7'd0, line_irq}, 8'h01);
    pal_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_offmode();
    t_perline();
    t_fullfield();
    t_edc();
    t_pal();
    t_hold();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule